// File: doc/BRIEF.md
# Serial DAC control core

This block is the digital front end of a single-channel voltage DAC. A host loads it over a three-wire serial link made of an active-low select, a serial clock and a data line. The core samples all three in its own system clock domain. It shifts data in on each falling serial-clock edge and decodes the two command bits at the head of each frame. It then updates a DAC code register and a power-state record. The analog converter, output buffer and termination resistors sit outside the block. The block drives them through a parallel code bus, a power-down flag and a two-bit termination select.

One parameter sets the code width. A 14-bit code travels in a 16-bit frame, and a 16-bit code travels in a 24-bit frame. A frame takes effect only on its last falling serial-clock edge. A frame that ends early is dropped. While the output is powered down, the DAC code is kept, so a later wake-up frame brings back the previous level. An active-low clear input zeroes the code registers without waiting for a clock edge and abandons any frame in progress. A synchronous active-high reset returns every output to zero.

Top module: `dacfe_core`

## Requirements
- R1: After reset, `dac_code` is 0, `pwr_down` is 0 and `term_mode` is 0.
- R2: Bits are sampled MSB first on falling `sclk` edges while `cs_n` is low. The two top frame bits are the command: 00 no-op, 01 write, 10 power control, 11 reserved. A write loads the code into `dac_code` on the final falling edge. The code sits in frame bits 13..0 of a 16-bit frame, or in bits 21..6 of a 24-bit frame.
- R3: If `cs_n` rises before the final falling edge, the frame is discarded and no output changes.
- R4: Falling edges after the final bit are ignored while `cs_n` stays low. A new frame starts only after a falling edge of `cs_n`.
- R5: A no-op frame (command 00) changes no output.
- R6: A reserved frame (command 11) changes no output.
- R7: In a power frame, the bit just below the command is a guard bit and must be 0. The next two bits are the mode. Modes 01 (high impedance), 10 (weak ground) and 11 (strong ground) set `pwr_down` to 1 and `term_mode` to the mode. `dac_code` keeps its value.
- R8: A power frame with mode 00 clears `pwr_down` and `term_mode` and restores the code held before power-down.
- R9: A write frame also clears `pwr_down` and `term_mode`, in the same cycle as it loads the code.
- R10: A power frame whose guard bit is 1 changes no output.
- R11: Driving `clr_n` low zeroes `dac_code` before the next clock edge and aborts the frame in flight. The remaining edges of that frame are ignored. The power state is kept.
- R12: The outputs change only on a committed frame, a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of the code registers |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is taken on falling edges |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | CODE_W | Code presented to the converter |
| pwr_down | output | 1 | Output stage powered down |
| term_mode | output | 2 | Termination select: 0 active, 1 high-Z, 2 weak, 3 strong |

## Verification
If the bit counter or the arm flag holds a wrong value, the error appears at the ports as a code committed on the wrong falling edge. It can also appear as a frame that never commits, or as a continuation after the last bit that overwrites the code. Each of these shows on `dac_code` one clock after the edge in question. If the register held during power-down is corrupted, the wrong level appears on `dac_code` one clock after the wake-up frame. If the power record is corrupted, `pwr_down` and `term_mode` disagree with the last power frame on the next cycle. The directed tests place a port check right after each of these edges, and both frame lengths are covered.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_POWER = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        TERM_ACTIVE = 2'b00,
        TERM_HIZ    = 2'b01,
        TERM_WEAK   = 2'b10,
        TERM_STRONG = 2'b11
    } term_e;

    typedef struct packed {
        cmd_e  cmd;
        logic  guard;
        term_e mode;
    } hdr_t;

    // Frame length for a given code width: narrow codes use the short frame.
    function automatic int frame_bits(input int code_w);
        return (code_w <= 14) ? 16 : 24;
    endfunction

endpackage

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic               sclk_q;
    logic               cs_q;
    logic               armed;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-2:0] shreg;
    logic               sclk_fall;
    logic               cs_fall;

    // Edge trackers for the serial lines, in the system clock domain.
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign sclk_fall = sclk_q && !sclk;
    assign cs_fall   = cs_q && !cs_n;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            armed <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
        end else if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
        end else if (cs_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (cs_fall) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (sclk_fall && armed) begin
            shreg <= {shreg[FRAME_W-3:0], sdi};
            if (cnt == LAST) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_vld  = !cs_n && armed && sclk_fall && (cnt == LAST);
    assign frame_word = {shreg, sdi};

    // R4
    idle_cnt_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        cs_n |=> (cnt == '0 && !armed));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/dacfe_decode.sv
module dacfe_decode
    import dacfe_pkg::*;
#(
    parameter int FRAME_W = 24,
    parameter int CODE_W  = 16
) (
    input  logic [FRAME_W-1:0] frame_word,
    output hdr_t               hdr,
    output logic [CODE_W-1:0]  code
);
    localparam int TOP = FRAME_W - 1;

    always_comb begin
        hdr.cmd   = cmd_e'(frame_word[TOP -: 2]);
        hdr.guard = frame_word[TOP-2];
        hdr.mode  = term_e'(frame_word[TOP-3 -: 2]);
    end

    assign code = frame_word[TOP-2 -: CODE_W];

    generate
        if (FRAME_W > CODE_W + 2) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^frame_word[FRAME_W-CODE_W-3:0];
        end
    endgenerate

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              frame_vld,
    input  hdr_t              hdr,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down,
    output logic [1:0]        term_mode
);
    logic [CODE_W-1:0] in_reg;
    logic [CODE_W-1:0] dac_reg;
    term_e             term_q;
    logic              pd_q;
    logic              do_write;
    logic              do_power;

    assign do_write = frame_vld && (hdr.cmd == CMD_WRITE);
    assign do_power = frame_vld && (hdr.cmd == CMD_POWER) && !hdr.guard;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_reg  <= '0;
            dac_reg <= '0;
        end else if (rst) begin
            in_reg  <= '0;
            dac_reg <= '0;
        end else if (do_write) begin
            in_reg  <= code;
            dac_reg <= code;
        end else if (do_power && hdr.mode == TERM_ACTIVE) begin
            dac_reg <= in_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q   <= 1'b0;
            term_q <= TERM_ACTIVE;
        end else if (do_write) begin
            pd_q   <= 1'b0;
            term_q <= TERM_ACTIVE;
        end else if (do_power) begin
            pd_q   <= (hdr.mode != TERM_ACTIVE);
            term_q <= hdr.mode;
        end
    end

    assign dac_code  = dac_reg;
    assign pwr_down  = pd_q;
    assign term_mode = term_q;

    // R12
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_code != $past(dac_code)) |->
            ($past(frame_vld) || !clr_n || !$past(clr_n) || $past(rst)));

    // R9
    wr_wake_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (frame_vld && hdr.cmd == CMD_WRITE) |=>
            (!pwr_down && term_mode == 2'b00 && dac_code == $past(code)));

    // R6
    rsvd_ign_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (frame_vld && hdr.cmd == CMD_RSVD) |=>
            ($stable(dac_code) && $stable(pwr_down) && $stable(term_mode)));

    // R7
    term_pd_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down == (term_mode != 2'b00));

endmodule

// File: rtl/dacfe_core.sv
module dacfe_core
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down,
    output logic [1:0]        term_mode
);
    localparam int FRAME_W = frame_bits(CODE_W);

    logic               frame_vld;
    logic [FRAME_W-1:0] frame_word;
    hdr_t               hdr;
    logic [CODE_W-1:0]  code;

    dacfe_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .frame_vld  (frame_vld),
        .frame_word (frame_word)
    );

    dacfe_decode #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_decode (
        .frame_word (frame_word),
        .hdr        (hdr),
        .code       (code)
    );

    dacfe_regs #(.CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .frame_vld (frame_vld),
        .hdr       (hdr),
        .code      (code),
        .dac_code  (dac_code),
        .pwr_down  (pwr_down),
        .term_mode (term_mode)
    );

endmodule

// File: tb/sim_dacfe_core.sv
module sim_dacfe_core;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1;
    logic cs0_n = 1'b1;
    logic cs1_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;

    logic [15:0] code0;
    logic        pd0;
    logic [1:0]  tm0;
    logic [13:0] code1;
    logic        pd1;
    logic [1:0]  tm1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dacfe_core #(.CODE_W(16)) u0 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs0_n), .sclk(sclk), .sdi(sdi),
        .dac_code(code0), .pwr_down(pd0), .term_mode(tm0)
    );

    dacfe_core #(.CODE_W(14)) u1 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs1_n), .sclk(sclk), .sdi(sdi),
        .dac_code(code1), .pwr_down(pd1), .term_mode(tm1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Checks {pwr_down, term_mode, code} of the 24-bit-frame instance.
    task automatic chk0(input string tag, input logic [15:0] c, input logic p, input logic [1:0] t);
        chk(tag, {13'b0, pd0, tm0, code0}, {13'b0, p, t, c});
    endtask

    task automatic cs_lo(input bit sel);
        @(negedge clk);
        if (sel) cs1_n = 1'b0; else cs0_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        @(negedge clk);
        cs0_n = 1'b1;
        cs1_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic clk_bits(input logic [23:0] w, input int flen, input int edges);
        for (int i = 0; i < edges; i++) begin
            sdi  = (i < flen) ? w[flen-1-i] : 1'b1;
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic frame0(input logic [23:0] w);
        cs_lo(0);
        clk_bits(w, 24, 24);
        cs_hi();
    endtask

    function automatic logic [23:0] wr24(input logic [15:0] c);
        return {2'b01, c, 6'b101010};
    endfunction

    function automatic logic [23:0] pw24(input logic g, input logic [1:0] m);
        return {2'b10, g, m, 19'h5A5A5};
    endfunction

    task automatic t_reset();
        chk0("R1 reset u0", 16'h0, 1'b0, 2'b00);
        chk("R1 reset u1", {15'b0, pd1, tm1, code1}, 32'h0);
    endtask

    task automatic t_write();
        frame0(wr24(16'hA5C3));
        chk0("R2 write 24-bit", 16'hA5C3, 1'b0, 2'b00);
        cs_lo(1);
        clk_bits({8'h0, 2'b01, 14'h2ABC}, 16, 16);
        cs_hi();
        chk("R2 write 16-bit frame", {15'b0, pd1, tm1, code1}, {15'b0, 1'b0, 2'b00, 14'h2ABC});
        // no commit before the last edge
        cs_lo(0);
        clk_bits(wr24(16'h1357), 24, 23);
        chk0("R12 no change before last edge", 16'hA5C3, 1'b0, 2'b00);
        clk_bits({23'b0, wr24(16'h1357)[0]}, 1, 1);
        chk0("R2 commit on last edge", 16'h1357, 1'b0, 2'b00);
        cs_hi();
    endtask

    task automatic t_short();
        cs_lo(0);
        clk_bits(wr24(16'hFFFF), 24, 20);
        cs_hi();
        chk0("R3 short frame dropped", 16'h1357, 1'b0, 2'b00);
        cs_lo(1);
        clk_bits({8'h0, 2'b01, 14'h0111}, 16, 15);
        cs_hi();
        chk("R3 short 16-bit frame dropped", {18'b0, code1}, {18'b0, 14'h2ABC});
    endtask

    task automatic t_extra();
        cs_lo(0);
        clk_bits(wr24(16'h0F0F), 24, 24);
        clk_bits(wr24(16'h7777), 24, 24);
        chk0("R4 continuation ignored", 16'h0F0F, 1'b0, 2'b00);
        cs_hi();
        chk0("R4 after select rise", 16'h0F0F, 1'b0, 2'b00);
    endtask

    task automatic t_nop_rsvd();
        frame0({2'b00, 22'h3FFFFF});
        chk0("R5 no-op ignored", 16'h0F0F, 1'b0, 2'b00);
        frame0({2'b11, 16'h1111, 6'h0});
        chk0("R6 reserved ignored", 16'h0F0F, 1'b0, 2'b00);
    endtask

    task automatic t_power();
        frame0(pw24(1'b0, 2'b10));
        chk0("R7 weak ground", 16'h0F0F, 1'b1, 2'b10);
        frame0(pw24(1'b0, 2'b01));
        chk0("R7 high impedance", 16'h0F0F, 1'b1, 2'b01);
        frame0(pw24(1'b0, 2'b11));
        chk0("R7 strong ground", 16'h0F0F, 1'b1, 2'b11);
        frame0(pw24(1'b1, 2'b00));
        chk0("R10 guard bit set ignored", 16'h0F0F, 1'b1, 2'b11);
        frame0(pw24(1'b0, 2'b00));
        chk0("R8 restore previous code", 16'h0F0F, 1'b0, 2'b00);
    endtask

    task automatic t_wake();
        frame0(pw24(1'b0, 2'b01));
        frame0(wr24(16'h4321));
        chk0("R9 write exits power-down", 16'h4321, 1'b0, 2'b00);
    endtask

    task automatic t_clear();
        frame0(pw24(1'b0, 2'b10));
        cs_lo(0);
        clk_bits(wr24(16'hBEEF), 24, 10);
        clr_n = 1'b0;
        #2;
        chk("R11 clear before clock edge", {16'b0, code0}, 32'h0);
        repeat (2) @(negedge clk);
        clr_n = 1'b1;
        clk_bits({wr24(16'hBEEF)[13:0], 10'b0}, 24, 14);
        chk0("R11 aborted frame, power kept", 16'h0000, 1'b1, 2'b10);
        cs_hi();
        frame0(wr24(16'h8001));
        chk0("R11 new frame after clear", 16'h8001, 1'b0, 2'b00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_short();
        t_extra();
        t_nop_rsvd();
        t_power();
        t_wake();
        t_clear();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule